// File: doc/BRIEF.md
# Host Unicast Destination Forwarding Filter

This block makes the forwarding choice for every frame that arrives at a three-port switch. The switch has two line ports and one host port. The block holds one 48-bit host station address. Software writes that address through a 16-bit register interface, one word at a time. For each frame the block takes the destination address and the ingress port code, and one clock later it presents a three-bit egress mask.

A unicast frame arriving from a line port goes to exactly one place. If its destination equals the programmed host address, it goes to the host port. Otherwise it passes through to the opposite line port. Group-addressed frames from a line port go to both the host and the opposite line port. Frames sent by the host go out on both line ports. While the stored address is all zeros, the block treats it as unprogrammed, and no unicast frame can reach the host.

The block does not buffer frames, check CRC or learn addresses. It only computes the decision.

Top module: `host_dest_filter`

## Requirements
- R1: The host address occupies three 16-bit words: bits 15:0 at offset 0x5A, bits 31:16 at offset 0x5C and bits 47:32 at offset 0x5E. A write with `regWrEn` high takes effect at the next clock edge. `regRdData` shows the word selected by `regAddr` combinationally.
- R2: After reset, all three address words read 0x0000, `fwdValid` is 0 and `fwdMask` is 000.
- R3: Each word can be written in any order. A write changes only the word it addresses.
- R4: Reads from any other offset return 0x0000. Writes to any other offset change no stored word.
- R5: Ingress codes are 0 for line port 1, 1 for line port 2 and 2 for the host. `fwdValid` is high in the cycle after each cycle in which `frmValid` is high, and low otherwise.
- R6: A destination is unicast when bit 40 of `frmDstAddr` is 0. This is the I/G bit of the first octet. Mask bit 0 is line port 1, bit 1 is line port 2 and bit 2 is the host. A unicast frame from a line port whose destination equals a nonzero host address gives mask 100.
- R7: A unicast frame from a line port whose destination differs from the host address gives a mask holding only the opposite line port.
- R8: While the host address is all zeros, a unicast frame from a line port never selects the host, even when its destination is all zeros.
- R9: A frame from a line port with bit 40 set (multicast or broadcast) gives the host plus the opposite line port.
- R10: Any frame from the host port gives mask 011.
- R11: The mask never includes the ingress port. Ingress code 3 gives mask 000.
- R12: `fwdMask` is 000 in every cycle in which `fwdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| frmValid | input | 1 | Frame header present this cycle |
| frmDstAddr | input | 48 | Destination address, first octet in bits 47:40 |
| frmIngress | input | 2 | Port the frame arrived on |
| fwdValid | output | 1 | Decision valid |
| fwdMask | output | 3 | Egress ports: bit 0 line 1, bit 1 line 2, bit 2 host |

## Verification
The bench uses the default parameters. These place the three address words at 0x5A, 0x5C and 0x5E, two bytes apart, with unmapped offsets between and beyond them. Single-byte misses such as 0x5B and 0x60 are therefore within reach of the decode checks.

Because the address is 48 bits wide, the tests can flip individual bits. They flip the I/G bit, the next bit up, the top bit and one bit in the middle word. This shows that every word enters the comparison, and that only bit 40 decides the group class. Programming only the low word, in a different order, shows that a partial address still counts as programmed.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
  localparam int MAC_W   = 48;
  localparam int DATA_W  = 16;
  localparam int NWORDS  = MAC_W / DATA_W;
  localparam int NPORTS  = 3;
  localparam int IG_BIT  = MAC_W - 8;

  localparam int BIT_L1   = 0;
  localparam int BIT_L2   = 1;
  localparam int BIT_HOST = 2;

  typedef enum logic [1:0] {
    ING_LINE1 = 2'd0,
    ING_LINE2 = 2'd1,
    ING_HOST  = 2'd2,
    ING_NONE  = 2'd3
  } ingress_e;

  typedef struct packed {
    logic [NWORDS-1:0] wrSel;
    logic [NWORDS-1:0] rdSel;
    logic              frmStb;
    logic [NPORTS-1:0] ingOneHot;
  } ctrlStrobe_t;
endpackage

// File: rtl/hdf_ctrl.sv
module hdf_ctrl
  import hdf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BASE_OFF = 'h5A,
  parameter int STRIDE   = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              frmValid,
  input  logic [1:0]        frmIngress,
  output ctrlStrobe_t       stb
);
  logic [NWORDS-1:0] hitWord;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_dec
    localparam logic [ADDR_W-1:0] WORD_OFF = ADDR_W'(BASE_OFF + STRIDE * gi);
    assign hitWord[gi] = (regAddr == WORD_OFF);
  end

  always_comb begin
    stb.rdSel  = hitWord;
    stb.wrSel  = regWrEn ? hitWord : '0;
    stb.frmStb = frmValid;
    stb.ingOneHot = '0;
    case (frmIngress)
      ING_LINE1: stb.ingOneHot[BIT_L1]   = 1'b1;
      ING_LINE2: stb.ingOneHot[BIT_L2]   = 1'b1;
      ING_HOST:  stb.ingOneHot[BIT_HOST] = 1'b1;
      default:   stb.ingOneHot = '0;
    endcase
  end
endmodule

// File: rtl/hdf_datapath.sv
module hdf_datapath
  import hdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [MAC_W-1:0]  frmDstAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              fwdValid,
  output logic [NPORTS-1:0] fwdMask
);
  logic [DATA_W-1:0] addrWord [NWORDS];
  logic [MAC_W-1:0]  hostAddr;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        addrWord[gi] <= '0;
      else if (stb.wrSel[gi])
        addrWord[gi] <= regWrData;
    end
    assign hostAddr[gi*DATA_W +: DATA_W] = addrWord[gi];

    // R3: a word moves only when its own write strobe is high
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.wrSel[gi] |=> $stable(addrWord[gi]));
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NWORDS; i++)
      if (stb.rdSel[i]) regRdData = regRdData | addrWord[i];
  end

  logic isUni, isProg, isHit, fromLine;
  logic [NPORTS-1:0] otherLine, nextMask;

  assign isUni    = !frmDstAddr[IG_BIT];
  assign isProg   = |hostAddr;
  assign isHit    = isUni && isProg && (frmDstAddr == hostAddr);
  assign fromLine = stb.ingOneHot[BIT_L1] || stb.ingOneHot[BIT_L2];

  always_comb begin
    otherLine = '0;
    if (stb.ingOneHot[BIT_L1]) otherLine[BIT_L2] = 1'b1;
    if (stb.ingOneHot[BIT_L2]) otherLine[BIT_L1] = 1'b1;
    nextMask = '0;
    if (stb.ingOneHot[BIT_HOST]) begin
      nextMask[BIT_L1] = 1'b1;
      nextMask[BIT_L2] = 1'b1;
    end else if (fromLine) begin
      if (!isUni) begin
        nextMask = otherLine;
        nextMask[BIT_HOST] = 1'b1;
      end else if (isHit) begin
        nextMask[BIT_HOST] = 1'b1;
      end else begin
        nextMask = otherLine;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwdValid <= 1'b0;
      fwdMask  <= '0;
    end else begin
      fwdValid <= stb.frmStb;
      fwdMask  <= stb.frmStb ? nextMask : '0;
    end
  end

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.frmStb |=> fwdValid);
  p_valid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.frmStb |=> !fwdValid);
  p_idle_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fwdValid |-> (fwdMask == '0));
  p_no_reflect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> ((fwdMask & $past(stb.ingOneHot)) == '0));
  p_uni_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwdValid && $past(isUni && fromLine)) |-> ($countones(fwdMask) == 1));
  p_unprog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwdValid && $past(isUni && hostAddr == '0)) |-> !fwdMask[BIT_HOST]);
  p_unmapped_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdSel == '0) |-> (regRdData == '0));
endmodule

// File: rtl/host_dest_filter.sv
module host_dest_filter
  import hdf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BASE_OFF = 'h5A,
  parameter int STRIDE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              frmValid,
  input  logic [47:0]       frmDstAddr,
  input  logic [1:0]        frmIngress,
  output logic              fwdValid,
  output logic [2:0]        fwdMask
);
  ctrlStrobe_t stb;

  hdf_ctrl #(
    .ADDR_W  (ADDR_W),
    .BASE_OFF(BASE_OFF),
    .STRIDE  (STRIDE)
  ) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .frmValid  (frmValid),
    .frmIngress(frmIngress),
    .stb       (stb)
  );

  hdf_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .regWrData (regWrData),
    .frmDstAddr(frmDstAddr),
    .regRdData (regRdData),
    .fwdValid  (fwdValid),
    .fwdMask   (fwdMask)
  );
endmodule

// File: tb/host_dest_filter_tb.sv
module host_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        frmValid = 1'b0;
  logic [47:0] frmDstAddr = '0;
  logic [1:0]  frmIngress = '0;
  logic        fwdValid;
  logic [2:0]  fwdMask;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  host_dest_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .frmValid(frmValid), .frmDstAddr(frmDstAddr), .frmIngress(frmIngress),
    .fwdValid(fwdValid), .fwdMask(fwdMask)
  );

  // entry: {ingress[1:0], dst[47:0], expected mask[2:0]}; host address 00-11-22-33-44-55
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {2'd0, 48'h001122334455, 3'b100},
    {2'd1, 48'h001122334455, 3'b100},
    {2'd0, 48'h001122334454, 3'b010},
    {2'd1, 48'h001122334454, 3'b001},
    {2'd0, 48'h011122334455, 3'b110},
    {2'd1, 48'hFFFFFFFFFFFF, 3'b101},
    {2'd2, 48'h001122334455, 3'b011},
    {2'd2, 48'hFFFFFFFFFFFF, 3'b011},
    {2'd3, 48'h001122334455, 3'b000},
    {2'd0, 48'h801122334455, 3'b010},
    {2'd1, 48'h001122234455, 3'b001},
    {2'd0, 48'h021122334455, 3'b010}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, req, 64'(regRdData), 64'(exp));
  endtask

  task automatic frm(input logic [1:0] ing, input logic [47:0] dst, input logic [2:0] exp, input string req);
    @(negedge clk);
    frmValid = 1'b1; frmDstAddr = dst; frmIngress = ing;
    @(negedge clk);
    frmValid = 1'b0;
    chk(fwdValid === 1'b1, "R5", 64'(fwdValid), 64'd1);
    chk(fwdMask === exp, req, 64'(fwdMask), 64'(exp));
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk(fwdValid === 1'b0, "R2", 64'(fwdValid), 64'd0);
    chk(fwdMask === 3'b000, "R2", 64'(fwdMask), 64'd0);
    rdChk(8'h5A, 16'h0000, "R2");
    rdChk(8'h5C, 16'h0000, "R2");
    rdChk(8'h5E, 16'h0000, "R2");

    // R8: unprogrammed address never matches
    frm(2'd0, 48'h000000000000, 3'b010, "R8");
    frm(2'd1, 48'h001122334455, 3'b001, "R8");

    // R1, R3: out-of-order programming and readback
    wr(8'h5E, 16'h0011);
    rdChk(8'h5E, 16'h0011, "R1");
    rdChk(8'h5A, 16'h0000, "R3");
    wr(8'h5A, 16'h4455);
    wr(8'h5C, 16'h2233);
    rdChk(8'h5A, 16'h4455, "R1");
    rdChk(8'h5C, 16'h2233, "R1");
    rdChk(8'h5E, 16'h0011, "R3");

    // R4: unmapped offsets
    wr(8'h5B, 16'hBEEF);
    wr(8'h60, 16'hCAFE);
    wr(8'h58, 16'h1234);
    rdChk(8'h5B, 16'h0000, "R4");
    rdChk(8'h60, 16'h0000, "R4");
    rdChk(8'h5A, 16'h4455, "R4");
    rdChk(8'h5C, 16'h2233, "R4");
    rdChk(8'h5E, 16'h0011, "R4");

    // table walk: R6 R7 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  ing;
      logic [47:0] dst;
      logic [2:0]  exp;
      string tag;
      {ing, dst, exp} = VEC[i];
      if (ing == 2'd2) tag = "R10";
      else if (ing == 2'd3) tag = "R11";
      else if (dst[40]) tag = "R9";
      else if (exp == 3'b100) tag = "R6";
      else tag = "R7";
      frm(ing, dst, exp, tag);
    end

    // R5, R12: decision drops after one cycle
    @(negedge clk);
    chk(fwdValid === 1'b0, "R5", 64'(fwdValid), 64'd0);
    chk(fwdMask === 3'b000, "R12", 64'(fwdMask), 64'd0);

    // back-to-back frames
    @(negedge clk);
    frmValid = 1'b1; frmDstAddr = 48'h001122334455; frmIngress = 2'd0;
    @(negedge clk);
    chk(fwdMask === 3'b100, "R6", 64'(fwdMask), 64'h4);
    frmIngress = 2'd1; frmDstAddr = 48'h0000000000AA;
    @(negedge clk);
    frmValid = 1'b0;
    chk(fwdValid === 1'b1 && fwdMask === 3'b001, "R7", 64'(fwdMask), 64'h1);

    // R3: partial address, only low word nonzero, still programmed
    wr(8'h5E, 16'h0000);
    wr(8'h5C, 16'h0000);
    frm(2'd1, 48'h000000004455, 3'b100, "R3");
    wr(8'h5A, 16'h0000);
    frm(2'd1, 48'h000000000000, 3'b001, "R8");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule